// File: doc/BRIEF.md
# Page Table Walk Unit

This unit translates a 32-bit virtual address into a physical address by fetching one page table entry from memory. The virtual address splits into a 20-bit virtual page number and a 12-bit page offset. The entry sits at the table base plus four times the virtual page number. The table base is a register that privileged software loads when it activates a process. The unit issues a single word read for the entry and then examines the entry's presence flag. For a resident page, it forms the physical address from the entry's frame number and the untouched offset. It also maintains the entry's recently-used and modified flags, and writes the entry back only when one of those flags actually changes. For a page that is not resident, it reports a page fault and does not touch memory again.

Translation requests enter on a valid/ready channel. `req_ready` is high only while the unit is idle, so a requester facing a busy unit simply holds its request. The result leaves as a one-cycle `rsp_valid` pulse with no back-pressure. The memory side is a request/ready channel: a held request may not change until memory accepts it. Read data returns on a separate `mem_rsp_valid` strobe, and a write is complete once memory accepts it.

Top module: `pte_walker`

## Requirements
- R1: After reset `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0. `req_ready` is 1 only while idle, and it drops in the cycle after a request is accepted (`req_valid && req_ready`).
- R2: The entry read goes to address base + (vaddr[31:12] << 2) with `mem_req_we` = 0.
- R3: A write on `base_wr_en` loads the table base and is used by later requests. A base write made after a request has been accepted does not change that request's entry address.
- R4: For an entry with bit 31 (present) set, the result has `rsp_fault` = 0 and `rsp_paddr` = {entry[19:0], vaddr[11:0]}.
- R5: For an entry with bit 31 clear, the result has `rsp_fault` = 1 and `rsp_paddr` = 0, and no memory write is issued.
- R6: A load to a present entry whose bit 29 (recently-used) is clear writes the entry back to the same address with bit 29 set and all other bits unchanged.
- R7: A store to a present entry sets both bit 29 and bit 30 (modified) in the written-back entry.
- R8: When the required flags are already set (bit 29 for a load, bits 29 and 30 for a store), no write is issued.
- R9: A memory request held while `mem_req_ready` is 0 keeps its valid, address, write enable and data unchanged, and the result stays correct under such stalls.
- R10: `rsp_valid` is a single-cycle pulse, and the unit is idle (`req_ready` = 1) in the cycle after it.
- R11: `mem_rsp_rdata` is ignored unless `mem_rsp_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr_en | input | 1 | Load the page table base |
| base_wr_data | input | 32 | New page table base |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | Access is a store |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_fault | output | 1 | Page not resident |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Entry byte address |
| mem_req_wdata | output | 32 | Updated entry to write |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read entry |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, 4 KB pages, 4-byte entries, and presence, modified and recently-used flags at bits 31, 30 and 29. Its memory model decodes a 256-word window, so it places two tables at different bases. This puts the base-change and mid-walk base-write cases within reach. The model's adjustable read latency and its patterned or total stalling of `mem_req_ready` exercise held memory requests, and they expose the unit to junk read data outside the strobe.

// File: rtl/pte_walk_pkg.sv
package pte_walk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_EVAL,
    ST_WR_REQ,
    ST_DONE
  } walk_state_t;
endpackage

// File: rtl/pte_addr_gen.sv
module pte_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int VPN_W      = 20,
  parameter int ENTRY_LOG2 = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [VPN_W-1:0]  vpn,
  output logic [ADDR_W-1:0] entry_addr
);
  always_comb begin
    entry_addr = base + (ADDR_W'(vpn) << ENTRY_LOG2);
  end
endmodule

// File: rtl/pte_flag_update.sv
module pte_flag_update #(
  parameter int PTE_W   = 32,
  parameter int PRES_BIT = 31,
  parameter int MOD_BIT  = 30,
  parameter int USED_BIT = 29
) (
  input  logic [PTE_W-1:0] pte_in,
  input  logic             is_store,
  output logic             present,
  output logic [PTE_W-1:0] pte_out,
  output logic             need_wb
);
  logic [PTE_W-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    set_mask[USED_BIT] = 1'b1;
    if (is_store) set_mask[MOD_BIT] = 1'b1;
    present = pte_in[PRES_BIT];
    pte_out = pte_in | set_mask;
    need_wb = present && (pte_out != pte_in);
  end
endmodule

// File: rtl/pte_walker.sv
module pte_walker
  import pte_walk_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_W     = 12,
  parameter int ADDR_W     = 32,
  parameter int PTE_W      = 32,
  parameter int PPN_W      = 20,
  parameter int ENTRY_LOG2 = 2,
  parameter int PRES_BIT   = 31,
  parameter int MOD_BIT    = 30,
  parameter int USED_BIT   = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr_en,
  input  logic [ADDR_W-1:0] base_wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_store,
  output logic              rsp_valid,
  output logic [PPN_W+PAGE_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [PTE_W-1:0]  mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_rdata
);
  localparam int VPN_W = VA_W - PAGE_W;
  localparam int PA_W  = PPN_W + PAGE_W;

  walk_state_t       state_q, state_d;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] ent_addr_q, ent_addr_d;
  logic [PAGE_W-1:0] offset_q;
  logic              store_q;
  logic [PTE_W-1:0]  pte_q;
  logic              present;
  logic              need_wb;
  logic [PTE_W-1:0]  pte_upd;
  logic              accept;

  assign accept = req_valid && req_ready;

  pte_addr_gen #(
    .ADDR_W(ADDR_W), .VPN_W(VPN_W), .ENTRY_LOG2(ENTRY_LOG2)
  ) u_addr (
    .base(base_q),
    .vpn(req_vaddr[VA_W-1:PAGE_W]),
    .entry_addr(ent_addr_d)
  );

  pte_flag_update #(
    .PTE_W(PTE_W), .PRES_BIT(PRES_BIT), .MOD_BIT(MOD_BIT), .USED_BIT(USED_BIT)
  ) u_flags (
    .pte_in(pte_q),
    .is_store(store_q),
    .present(present),
    .pte_out(pte_upd),
    .need_wb(need_wb)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = ST_RD_REQ;
      ST_RD_REQ:  if (mem_req_ready) state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (mem_rsp_valid) state_d = ST_EVAL;
      ST_EVAL:    state_d = need_wb ? ST_WR_REQ : ST_DONE;
      ST_WR_REQ:  if (mem_req_ready) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      base_q     <= '0;
      ent_addr_q <= '0;
      offset_q   <= '0;
      store_q    <= 1'b0;
      pte_q      <= '0;
    end else begin
      state_q <= state_d;
      if (base_wr_en) base_q <= base_wr_data;
      if (accept) begin
        ent_addr_q <= ent_addr_d;
        offset_q   <= req_vaddr[PAGE_W-1:0];
        store_q    <= req_store;
      end
      if (state_q == ST_RD_WAIT && mem_rsp_valid) pte_q <= mem_rsp_rdata;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign mem_req_we    = (state_q == ST_WR_REQ);
  assign mem_req_addr  = ent_addr_q;
  assign mem_req_wdata = mem_req_we ? pte_upd : '0;
  assign rsp_valid     = (state_q == ST_DONE);
  assign rsp_fault     = rsp_valid && !present;
  assign rsp_paddr     = (rsp_valid && present) ? PA_W'({pte_q[PPN_W-1:0], offset_q}) : '0;

  // R1: accepting a request makes the unit busy on the next cycle
  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9: a stalled memory request holds its contents
  p_hold_mem_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr) && $stable(mem_req_wdata)));

  // R10: result is a single-cycle pulse followed by idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R5: a non-resident entry is never written back
  p_no_fault_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> mem_req_wdata[PRES_BIT]);

  // R6: written-back entries always carry the recently-used flag
  p_wb_used_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> mem_req_wdata[USED_BIT]);

  // R5: a fault result never reports an address
  p_fault_zero_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && rsp_paddr == '0));
endmodule

// File: tb/sim_pte_walker.sv
module sim_pte_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_wr_en = 1'b0;
  logic [31:0] base_wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_store = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic        mem_req_we;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pte_walker u0 (
    .clk(clk), .rst_n(rst_n),
    .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_store(req_store),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  // memory model
  logic [31:0] mem [0:255];
  int          rd_lat = 0;
  logic        stall_pat = 1'b0;
  logic        stall_all = 1'b0;
  logic [3:0]  free_ctr = '0;
  logic        pend = 1'b0;
  int          pcnt = 0;
  logic [7:0]  pidx = '0;
  int          wr_count = 0;
  logic [31:0] last_wr_addr = '0;
  logic [31:0] last_wr_data = '0;
  logic [31:0] last_rd_addr = '0;

  assign mem_req_ready = !stall_all && (!stall_pat || free_ctr[1:0] == 2'd3);

  always @(posedge clk) begin
    free_ctr      <= free_ctr + 4'd1;
    mem_rsp_valid <= 1'b0;
    mem_rsp_rdata <= 32'h1234_5678;
    if (pend) begin
      if (pcnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem[pidx];
        pend <= 1'b0;
      end else begin
        pcnt <= pcnt - 1;
      end
    end
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr[9:2]] <= mem_req_wdata;
        wr_count     <= wr_count + 1;
        last_wr_addr <= mem_req_addr;
        last_wr_data <= mem_req_wdata;
      end else begin
        pend         <= 1'b1;
        pcnt         <= rd_lat;
        pidx         <= mem_req_addr[9:2];
        last_rd_addr <= mem_req_addr;
      end
    end
  end

  logic [31:0] got_paddr;
  logic        got_fault;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_wr_en   = 1'b1;
    base_wr_data = b;
    @(negedge clk);
    base_wr_en   = 1'b0;
  endtask

  task automatic put_pte(input logic [31:0] addr, input logic [31:0] v);
    @(negedge clk);
    mem[addr[9:2]] <= v;
    @(negedge clk);
  endtask

  task automatic do_walk(input logic [31:0] va, input logic st);
    int n;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_store = st;
    n = 0;
    while (!req_ready && n < 50) begin @(negedge clk); n++; end
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R1", "ready low while busy", {31'd0, req_ready}, 32'd0);
    n = 0;
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    check(rsp_valid == 1'b1, "R10", "result arrived", {31'd0, rsp_valid}, 32'd1);
    got_paddr = rsp_paddr;
    got_fault = rsp_fault;
    @(negedge clk);
    check(!rsp_valid && req_ready, "R10", "single pulse then idle",
          {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  task automatic t_reset;
    check(req_ready == 1'b1, "R1", "reset ready", {31'd0, req_ready}, 32'd1);
    check(rsp_valid == 1'b0, "R1", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check(mem_req_valid == 1'b0, "R1", "reset mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
  endtask

  task automatic t_hit_no_update;
    int w0;
    set_base(32'h200);
    put_pte(32'h214, 32'hA00A_BCDE);   // present + used, frame ABCDE
    w0 = wr_count;
    do_walk(32'h0000_5123, 1'b0);
    check(last_rd_addr == 32'h214, "R2", "entry address", last_rd_addr, 32'h214);
    check(!got_fault && got_paddr == 32'hABCD_E123, "R4", "translated address", got_paddr, 32'hABCD_E123);
    check(wr_count == w0, "R8", "no write when used set", wr_count, w0);
  endtask

  task automatic t_load_sets_used;
    int w0;
    put_pte(32'h218, 32'h8001_1111);
    w0 = wr_count;
    do_walk(32'h0000_6FFF, 1'b0);
    check(got_paddr == 32'h1111_1FFF, "R4", "load address", got_paddr, 32'h1111_1FFF);
    check(wr_count == w0 + 1 && last_wr_addr == 32'h218, "R6", "writeback address", last_wr_addr, 32'h218);
    check(last_wr_data == 32'hA001_1111, "R6", "used bit set", last_wr_data, 32'hA001_1111);
  endtask

  task automatic t_store_sets_both;
    int w0;
    put_pte(32'h21C, 32'h8002_2222);
    w0 = wr_count;
    do_walk(32'h0000_7004, 1'b1);
    check(wr_count == w0 + 1 && last_wr_data == 32'hE002_2222, "R7", "store flags", last_wr_data, 32'hE002_2222);
    w0 = wr_count;
    do_walk(32'h0000_7008, 1'b1);
    check(wr_count == w0, "R8", "no write when both set", wr_count, w0);
    check(got_paddr == 32'h2222_2008, "R4", "store address", got_paddr, 32'h2222_2008);
  endtask

  task automatic t_fault;
    int w0;
    put_pte(32'h220, 32'h0000_0ABC);
    w0 = wr_count;
    do_walk(32'h0000_8010, 1'b1);
    check(got_fault == 1'b1, "R5", "fault flag", {31'd0, got_fault}, 32'd1);
    check(got_paddr == 32'd0, "R5", "fault address zero", got_paddr, 32'd0);
    check(wr_count == w0, "R5", "no write on fault", wr_count, w0);
  endtask

  task automatic t_base_change;
    put_pte(32'h304, 32'hA003_3333);
    set_base(32'h300);
    do_walk(32'h0000_1ABC, 1'b0);
    check(last_rd_addr == 32'h304, "R3", "new base used", last_rd_addr, 32'h304);
    check(got_paddr == 32'h3333_3ABC, "R3", "new base result", got_paddr, 32'h3333_3ABC);
  endtask

  task automatic t_base_midwalk;
    int n;
    put_pte(32'h308, 32'hA004_4444);
    stall_all = 1'b1;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = 32'h0000_2010;
    req_store = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    base_wr_en = 1'b1;
    base_wr_data = 32'h200;
    @(negedge clk);
    base_wr_en = 1'b0;
    repeat (2) @(negedge clk);
    stall_all = 1'b0;
    n = 0;
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    check(last_rd_addr == 32'h308, "R3", "base write after accept ignored", last_rd_addr, 32'h308);
    check(rsp_paddr == 32'h4444_4010, "R3", "mid-walk result", rsp_paddr, 32'h4444_4010);
    @(negedge clk);
  endtask

  task automatic t_backpressure;
    int w0;
    put_pte(32'h224, 32'h8005_5555);
    stall_pat = 1'b1;
    rd_lat = 3;
    w0 = wr_count;
    do_walk(32'h0000_9777, 1'b1);
    check(got_paddr == 32'h5555_5777 && !got_fault, "R11", "junk data outside strobe ignored", got_paddr, 32'h5555_5777);
    check(wr_count == w0 + 1 && last_wr_data == 32'hE005_5555, "R9", "stalled writeback", last_wr_data, 32'hE005_5555);
    stall_pat = 1'b0;
    rd_lat = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hit_no_update();
    t_load_sets_used();
    t_store_sets_both();
    t_fault();
    t_base_change();
    t_base_midwalk();
    t_backpressure();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule